// File: doc/BRIEF.md
# Byte-Stream Program Image Loader

The block receives a program image as a stream of bytes over a valid/ready handshake, with a marker on the final byte. It joins the bytes into 16-bit words with the high byte first. The first word is not data: it is the load origin. Every word after it is written into word memory at consecutive addresses, starting at that origin. When the image ends cleanly, the loader pulses `done` and, in the same cycle, presents the origin on a program-counter load port. A core can then start executing at the start of the image.

Malformed images raise `err` for one cycle, with a cause code. An image is malformed if it ends on an unpaired byte, which also covers an image of only one byte. It is also malformed if it holds more data words than fit between the origin and the top of the address space. After an address-range error, the loader accepts and discards the rest of the image up to its last byte, so that the next image starts from a clean stream.

The controller has five named states:
- `ST_RECV` accepts bytes.
- `ST_WRITE` issues one memory write.
- `ST_DONE` pulses completion.
- `ST_ERR` pulses the error.
- `ST_DRAIN` discards bytes after a range error.

The transitions are as follows:
- From `ST_RECV`:
  - To `ST_WRITE` on each completed data word.
  - To `ST_DONE` on a last byte that completes the origin word.
  - To `ST_ERR` on a last byte that leaves a word unpaired.
  - To `ST_ERR` on a data word that would fall past the top address.
- From `ST_WRITE`:
  - To `ST_DONE` if that word ended the image.
  - Otherwise back to `ST_RECV`.
- From `ST_DONE`, always back to `ST_RECV`.
- From `ST_ERR`:
  - To `ST_RECV` if the last byte has already been taken.
  - Otherwise to `ST_DRAIN`.
- From `ST_DRAIN`, to `ST_RECV` when the last byte is accepted.

Top module: `img_word_loader`

## Requirements
- R1: Two accepted bytes form one word as {first byte, second byte}, so the first byte is bits 15:8 and the second byte is bits 7:0.
- R2: The first word of an image is taken as the origin and is never written to memory.
- R3: The k-th data word (k from 0) is written once, at address origin+k, in stream order. Each write is a one-cycle `mem_we` pulse.
- R4: When an image ends on a complete word, `done` and `pc_load` pulse high together for exactly one cycle, with `pc_value` equal to the origin. An image holding only the origin word is valid and produces no writes.
- R5: When the last byte leaves a word unpaired (odd length, including a one-byte image), `err` pulses for one cycle with `err_cause` = 2'b01. No `done` follows, and the partial word is not written.
- R6: A data word that would go to an address above 0xFFFF is not written. Instead `err` pulses with `err_cause` = 2'b10. An image whose final word lands exactly at 0xFFFF is valid.
- R7: `in_ready` is low in every cycle where `mem_we`, `done` or `err` is high.
- R8: After a range error on a byte that is not last, bytes keep being accepted and are discarded through the last byte. This causes no write, no `done` and no further `err`.
- R9: After `done` or `err` (and any discard), the loader is back in `ST_RECV`, and the next image loads with a fresh origin.
- R10: After reset, `in_ready` = 1, and `mem_we`, `done`, `pc_load` and `err` = 0, with `err_cause` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is valid |
| in_byte | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte of the image |
| in_ready | output | 1 | Loader can accept a byte this cycle |
| mem_we | output | 1 | Word memory write strobe |
| mem_addr | output | 16 | Word memory write address |
| mem_wdata | output | 16 | Word memory write data |
| pc_load | output | 1 | Load `pc_value` into the program counter |
| pc_value | output | 16 | Origin of the completed image |
| done | output | 1 | One-cycle image-complete pulse |
| err | output | 1 | One-cycle malformed-image pulse |
| err_cause | output | 2 | 01 unpaired byte, 10 address range; 00 when `err` is low |

## Verification
The checks assume that the sender follows the handshake: a byte counts only in a cycle where both `in_valid` and `in_ready` are high, and `in_last` marks exactly one byte per image. The address-step and top-address checks assume that every image starts from a fresh origin, so write tracking is reset on each `done` or `err`. The bench drives each byte at the falling edge and holds it until `in_ready` is seen high. It sets `in_last` only on the final byte of each image, and feeds images only with complete framing, including those that are deliberately malformed in length or range.

// File: rtl/img_ldr_pkg.sv
package img_ldr_pkg;

    typedef enum logic [2:0] {
        ST_RECV  = 3'd0,
        ST_WRITE = 3'd1,
        ST_DONE  = 3'd2,
        ST_ERR   = 3'd3,
        ST_DRAIN = 3'd4
    } ldr_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_LENGTH = 2'b01,
        CAUSE_RANGE  = 2'b10
    } ldr_cause_e;

endpackage

// File: rtl/ldr_byte_pair.sv
module ldr_byte_pair #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              half_full,
    output logic [WORD_W-1:0] word_out
);

    logic [BYTE_W-1:0] hi_q;

    // The high byte is held until its partner arrives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            half_full <= 1'b0;
        end else if (clear) begin
            half_full <= 1'b0;
        end else if (take) begin
            if (!half_full) begin
                hi_q <= byte_in;
            end
            half_full <= ~half_full;
        end
    end

    // The word is complete in the same cycle that the low byte is taken.
    assign word_out = {hi_q, byte_in};

endmodule

// File: rtl/ldr_addr_gen.sv
module ldr_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              set_origin,
    input  logic [ADDR_W-1:0] origin_in,
    input  logic              advance,
    output logic [ADDR_W-1:0] origin_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              have_origin,
    output logic              exhausted
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            origin_q    <= '0;
            addr_q      <= '0;
            have_origin <= 1'b0;
            exhausted   <= 1'b0;
        end else if (clear) begin
            have_origin <= 1'b0;
            exhausted   <= 1'b0;
        end else if (set_origin) begin
            origin_q    <= origin_in;
            addr_q      <= origin_in;
            have_origin <= 1'b1;
            exhausted   <= 1'b0;
        end else if (advance) begin
            // A write at the top address uses up the last slot.
            if (addr_q == TOP_ADDR) begin
                exhausted <= 1'b1;
            end
            addr_q <= addr_q + 1'b1;
        end
    end

endmodule

// File: rtl/img_word_loader.sv
module img_word_loader #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [BYTE_W-1:0]     in_byte,
    input  logic                  in_last,
    output logic                  in_ready,
    output logic                  mem_we,
    output logic [2*BYTE_W-1:0]   mem_addr,
    output logic [2*BYTE_W-1:0]   mem_wdata,
    output logic                  pc_load,
    output logic [2*BYTE_W-1:0]   pc_value,
    output logic                  done,
    output logic                  err,
    output logic [1:0]            err_cause
);

    import img_ldr_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = WORD_W;

    ldr_state_e state_q, state_d;

    logic              accept;
    logic              take_byte;
    logic              half_full;
    logic [WORD_W-1:0] word_now;
    logic              clear_img;
    logic              set_origin;
    logic              advance;
    logic [ADDR_W-1:0] origin_q;
    logic [ADDR_W-1:0] addr_q;
    logic              have_origin;
    logic              exhausted;

    logic              word_done;
    logic              store_word;
    logic              set_cause;
    ldr_cause_e        cause_d;

    logic [WORD_W-1:0] word_q;
    logic              last_q;
    ldr_cause_e        cause_q;

    assign accept    = in_valid && in_ready;
    assign take_byte = accept && (state_q == ST_RECV);
    assign word_done = take_byte && half_full;

    ldr_byte_pair #(.BYTE_W(BYTE_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_img),
        .take      (take_byte),
        .byte_in   (in_byte),
        .half_full (half_full),
        .word_out  (word_now)
    );

    ldr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear_img),
        .set_origin  (set_origin),
        .origin_in   (word_now),
        .advance     (advance),
        .origin_q    (origin_q),
        .addr_q      (addr_q),
        .have_origin (have_origin),
        .exhausted   (exhausted)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECV;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and datapath control
    always_comb begin
        state_d    = state_q;
        set_origin = 1'b0;
        store_word = 1'b0;
        set_cause  = 1'b0;
        cause_d    = CAUSE_NONE;
        advance    = 1'b0;
        clear_img  = 1'b0;
        unique case (state_q)
            ST_RECV: begin
                if (take_byte && !half_full && in_last) begin
                    state_d   = ST_ERR;
                    set_cause = 1'b1;
                    cause_d   = CAUSE_LENGTH;
                end else if (word_done && !have_origin) begin
                    set_origin = 1'b1;
                    if (in_last) begin
                        state_d = ST_DONE;
                    end
                end else if (word_done && exhausted) begin
                    state_d   = ST_ERR;
                    set_cause = 1'b1;
                    cause_d   = CAUSE_RANGE;
                end else if (word_done) begin
                    state_d    = ST_WRITE;
                    store_word = 1'b1;
                end
            end
            ST_WRITE: begin
                advance = 1'b1;
                state_d = last_q ? ST_DONE : ST_RECV;
            end
            ST_DONE: begin
                clear_img = 1'b1;
                state_d   = ST_RECV;
            end
            ST_ERR: begin
                clear_img = 1'b1;
                state_d   = last_q ? ST_RECV : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (accept && in_last) begin
                    state_d = ST_RECV;
                end
            end
            default: begin
                state_d = ST_RECV;
            end
        endcase
    end

    // Held word, last marker and error cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            last_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            if (accept) begin
                last_q <= in_last;
            end
            if (store_word) begin
                word_q <= word_now;
            end
            if (set_cause) begin
                cause_q <= cause_d;
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        done      = 1'b0;
        pc_load   = 1'b0;
        err       = 1'b0;
        err_cause = CAUSE_NONE;
        unique case (state_q)
            ST_RECV:  in_ready = 1'b1;
            ST_DRAIN: in_ready = 1'b1;
            ST_WRITE: mem_we   = 1'b1;
            ST_DONE: begin
                done    = 1'b1;
                pc_load = 1'b1;
            end
            ST_ERR: begin
                err       = 1'b1;
                err_cause = cause_q;
            end
            default: in_ready = 1'b0;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = word_q;
    assign pc_value  = origin_q;

endmodule

// File: rtl/ldr_img_checker.sv
module ldr_img_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic              pc_load,
    input logic              done,
    input logic              err,
    input logic [1:0]        err_cause
);

    localparam logic [WORD_W-1:0] TOP_ADDR = '1;

    logic              prev_valid;
    logic [WORD_W-1:0] prev_addr;
    logic              top_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_addr  <= '0;
            top_hit    <= 1'b0;
        end else if (done || err) begin
            prev_valid <= 1'b0;
            top_hit    <= 1'b0;
        end else if (mem_we) begin
            prev_valid <= 1'b1;
            prev_addr  <= mem_addr;
            if (mem_addr == TOP_ADDR) begin
                top_hit <= 1'b1;
            end
        end
    end

    assert_write_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && prev_valid) |-> (mem_addr == prev_addr + 1'b1));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !top_hit);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_pc_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pc_load);

    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_cause != 2'b00));

    assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || done || err) |-> !in_ready);

    assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_we, done, err}) <= 1);

endmodule

bind img_word_loader ldr_img_checker #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/img_word_loader_tb.sv
`timescale 1ns/1ps
module img_word_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        pc_load;
    logic [15:0] pc_value;
    logic        done;
    logic        err;
    logic [1:0]  err_cause;

    int n_checks = 0;
    int n_fail = 0;

    int          n_wr;
    logic [15:0] wr_addr [64];
    logic [15:0] wr_data [64];
    int          n_done;
    logic [15:0] seen_pc;
    int          n_err;
    logic [1:0]  seen_cause;
    int          rdy_viol;

    logic [7:0] img [64];
    int         img_len;

    always #10 clk = ~clk;

    img_word_loader u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc_load   (pc_load),
        .pc_value  (pc_value),
        .done      (done),
        .err       (err),
        .err_cause (err_cause)
    );

    // Event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (n_wr < 64) begin
                    wr_addr[n_wr] = mem_addr;
                    wr_data[n_wr] = mem_wdata;
                end
                n_wr++;
            end
            if (done && pc_load) begin
                n_done++;
                seen_pc = pc_value;
            end
            if (err) begin
                n_err++;
                seen_cause = err_cause;
            end
            if ((mem_we || done || err) && in_ready) begin
                rdy_viol++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_wr = 0; n_done = 0; n_err = 0; rdy_viol = 0;
        seen_pc = '0; seen_cause = '0; img_len = 0;
    endtask

    task automatic push(input logic [7:0] b);
        img[img_len] = b;
        img_len++;
    endtask

    task automatic push_word(input logic [15:0] w);
        push(w[15:8]);
        push(w[7:0]);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic stream(input bit gaps);
        for (int i = 0; i < img_len; i++) begin
            send_byte(img[i], i == img_len - 1);
            if (gaps) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10", "in_ready", in_ready, 1);
        chk("R10", "mem_we", mem_we, 0);
        chk("R10", "done", done, 0);
        chk("R10", "pc_load", pc_load, 0);
        chk("R10", "err", err, 0);
        chk("R10", "err_cause", err_cause, 0);
    endtask

    task automatic t_basic();
        clear_log();
        push_word(16'h3000);
        push_word(16'h5020);
        push_word(16'h5260);
        push_word(16'h1023);
        stream(1'b1);
        chk("R2", "write count", n_wr, 3);
        chk("R3", "addr0", wr_addr[0], 16'h3000);
        chk("R1", "data0", wr_data[0], 16'h5020);
        chk("R3", "addr1", wr_addr[1], 16'h3001);
        chk("R1", "data1", wr_data[1], 16'h5260);
        chk("R3", "addr2", wr_addr[2], 16'h3002);
        chk("R3", "data2", wr_data[2], 16'h1023);
        chk("R4", "done count", n_done, 1);
        chk("R4", "pc", seen_pc, 16'h3000);
        chk("R5", "no err", n_err, 0);
        chk("R7", "ready violations", rdy_viol, 0);
    endtask

    task automatic t_back_to_back();
        clear_log();
        push_word(16'hA5C3);
        push_word(16'h0102);
        push_word(16'hFF00);
        stream(1'b0);
        chk("R1", "data0", wr_data[0], 16'h0102);
        chk("R3", "addr1", wr_addr[1], 16'hA5C4);
        chk("R1", "data1", wr_data[1], 16'hFF00);
        chk("R4", "pc", seen_pc, 16'hA5C3);
        chk("R7", "ready violations", rdy_viol, 0);
    endtask

    task automatic t_header_only();
        clear_log();
        push_word(16'h1234);
        stream(1'b0);
        chk("R2", "no writes", n_wr, 0);
        chk("R4", "done count", n_done, 1);
        chk("R4", "pc", seen_pc, 16'h1234);
    endtask

    task automatic t_odd();
        clear_log();
        push_word(16'h4000);
        push_word(16'hBEEF);
        push(8'h77);
        stream(1'b0);
        chk("R5", "writes before tail", n_wr, 1);
        chk("R5", "err count", n_err, 1);
        chk("R5", "cause", seen_cause, 2'b01);
        chk("R5", "no done", n_done, 0);
    endtask

    task automatic t_single();
        clear_log();
        push(8'h30);
        stream(1'b0);
        chk("R5", "err count", n_err, 1);
        chk("R5", "cause", seen_cause, 2'b01);
        chk("R5", "no done", n_done, 0);
        chk("R5", "no writes", n_wr, 0);
    endtask

    task automatic t_exact_top();
        clear_log();
        push_word(16'hFFFE);
        push_word(16'h1111);
        push_word(16'h2222);
        stream(1'b0);
        chk("R6", "writes", n_wr, 2);
        chk("R6", "top addr", wr_addr[1], 16'hFFFF);
        chk("R6", "no err", n_err, 0);
        chk("R6", "done", n_done, 1);
    endtask

    task automatic t_overflow_drain();
        clear_log();
        push_word(16'hFFFF);
        push_word(16'hAAAA);
        push_word(16'hBBBB);
        push_word(16'hCCCC);
        push_word(16'hDDDD);
        stream(1'b0);
        chk("R6", "writes", n_wr, 1);
        chk("R6", "addr", wr_addr[0], 16'hFFFF);
        chk("R6", "err count", n_err, 1);
        chk("R6", "cause", seen_cause, 2'b10);
        chk("R8", "no done", n_done, 0);
        chk("R8", "ready after drain", in_ready, 1);
        chk("R7", "ready violations", rdy_viol, 0);
        // The next image must load with a fresh origin.
        clear_log();
        push_word(16'h0040);
        push_word(16'hBEEF);
        stream(1'b0);
        chk("R9", "writes", n_wr, 1);
        chk("R9", "addr", wr_addr[0], 16'h0040);
        chk("R9", "data", wr_data[0], 16'hBEEF);
        chk("R9", "pc", seen_pc, 16'h0040);
        chk("R9", "no err", n_err, 0);
    endtask

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_back_to_back();
        t_header_only();
        t_odd();
        t_single();
        t_basic();
        t_exact_top();
        t_overflow_drain();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule